// File: doc/BRIEF.md
# Set-Associative Write-Through Unified Cache

This block is the first-level cache shared by instruction fetch and data loads in a 32-bit pipeline. The execute stage drives the next request address before it is registered. The cache uses that early address to read its tag, valid and data arrays, captures the request on the same edge, and compares the captured tag with the array outputs one cycle later. On a read hit the selected word goes straight to the decode stage with no memory traffic and no stall. On a read miss the cache raises `stall`, refills the whole line through a simple request/acknowledge memory port, and then returns the requested word. Stores are forwarded to memory as single writes. A store that hits also updates the cached word, and a store that misses allocates nothing. A swap request removes any cached copy of its line and then performs a locked read followed by a write to the same address in memory. A flush input clears every valid bit, one set per cycle.

Addresses split into a byte offset in bits [1:0], a word offset in [3:2], a set index in [11:4] and a tag in [31:12]. The default organisation has 4 ways, 256 sets and 4 words per line, giving 16 KB. A request is taken at any rising edge where `stall` is low. While `stall` is high the core holds `req_*` and `flush` steady.

The controller has these states. IDLE means no request is pending. LOOKUP compares the captured request. FILL reads the four words of a line. STORE waits for a write acknowledge. SWAP_RD and SWAP_WR carry out the locked read and write. DONE returns a buffered word for one cycle. FLUSH clears valid bits.

The transitions are as follows:
- IDLE, DONE and a LOOKUP read hit all capture the next input: to FLUSH if `flush` is high, to LOOKUP if `req_valid` is high, otherwise to IDLE.
- LOOKUP goes to SWAP_RD for a swap, to STORE for a store, and to FILL for a read miss.
- FILL goes to DONE on the fourth acknowledge.
- STORE goes to DONE on its acknowledge.
- SWAP_RD goes to SWAP_WR on its acknowledge, and SWAP_WR goes to DONE on its acknowledge.
- FLUSH goes to IDLE after the last set.

Top module: `ucache_top`

## Requirements
- R1: After reset `stall`, `rd_valid` and `mem_req` are low, and every line is invalid, so the first read of any address misses.
- R2: A read hit raises `rd_valid` with the cached word in the cycle after the request is taken, keeps `stall` low, and issues no memory request.
- R3: A read miss holds `stall` high while exactly four single-word memory reads fetch the line, at the line base address with word offsets [3:2] in the order 0, 1, 2, 3. `rd_valid` then returns the requested word with `stall` low.
- R4: After a refill, reads of any other word in that line hit.
- R5: Every store produces one memory write (`mem_we` high) with `stall` held until its acknowledge. A store that hits updates the cached word, so a later read hits and returns the new value.
- R6: A store that misses allocates no line, so a later read of that address misses.
- R7: A swap drives `mem_lock` high on one memory read and then one write to the same address. `rd_valid` returns the word that memory held before the write. Any cached copy of the line is invalidated, so the next read of it misses and returns the swapped-in value.
- R8: On a miss an invalid way is chosen before a valid one (otherwise a free-running round-robin way), so four different tags read into one set all remain resident.
- R9: A flush taken at an edge with `stall` low holds `stall` high for exactly 256 cycles, and afterwards all lines are invalid.
- R10: At most one way hits for a lookup, and a memory request keeps `mem_req` high with a stable address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Request to invalidate all lines |
| req_valid | input | 1 | Core request present |
| req_addr | input | 32 | Unregistered request address |
| req_write | input | 1 | Request is a store |
| req_swap | input | 1 | Request is an atomic swap |
| req_wdata | input | 32 | Store or swap data |
| stall | output | 1 | Pipeline must hold its request |
| rd_valid | output | 1 | Read data valid to decode |
| rd_data | output | 32 | Read data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_lock | output | 1 | Transfer belongs to a locked swap pair |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transfer complete |
| mem_rdata | input | 32 | Memory read data |

## Verification
A corrupted tag or valid bit shows up on the very next lookup of that set in one of two ways. Either `rd_valid` returns a stale word one cycle after the request, or a read that should hit turns into four extra memory reads. Wrong refill sequencing appears at once on `mem_addr` as a skipped or repeated word offset. A missed swap invalidation stays hidden until the line is next read, and that read then hits with old data instead of missing. A bad victim choice shows only after a set has taken four distinct tags, when a resident line misses again.

// File: rtl/ucache_pkg.sv
package ucache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_STORE,
        ST_SWAP_RD,
        ST_SWAP_WR,
        ST_DONE,
        ST_FLUSH
    } cache_state_e;
endpackage

// File: rtl/ucache_tag_way.sv
module ucache_tag_way #(
    parameter int SETS  = 256,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx,
    output logic [TAG_W-1:0] tag_q,
    output logic             valid_q
);
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  valid_r;

    always_ff @(posedge clk) begin
        if (fill_en) tags[fill_idx] <= fill_tag;
        tag_q <= tags[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_r <= '0;
            valid_q <= 1'b0;
        end else begin
            if (fill_en)  valid_r[fill_idx]  <= 1'b1;
            if (inval_en) valid_r[inval_idx] <= 1'b0;
            valid_q <= valid_r[rd_idx];
        end
    end
endmodule

// File: rtl/ucache_data_way.sv
module ucache_data_way #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr] <= wr_data;
        rd_q <= words[rd_addr];
    end
endmodule

// File: rtl/ucache_victim.sv
module ucache_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  valid_vec,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] rr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
    end

    always_comb begin
        victim = rr_q;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/ucache_top.sv
module ucache_top
    import ucache_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 256,
    parameter int LINE_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_swap,
    input  logic [31:0] req_wdata,
    output logic        stall,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_lock,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int OFS_W   = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(SETS);
    localparam int IDX_LSB = 2 + OFS_W;
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_W   = 32 - TAG_LSB;
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int DEPTH   = SETS * LINE_WORDS;
    localparam logic [OFS_W-1:0] LAST_WORD = OFS_W'(LINE_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_SET  = IDX_W'(SETS - 1);

    cache_state_e state_q, state_d;

    logic [31:0]       r_addr, r_wdata;
    logic              r_write, r_swap;
    logic [TAG_W-1:0]  r_tag;
    logic [IDX_W-1:0]  r_idx;
    logic [OFS_W-1:0]  r_word;
    logic [OFS_W-1:0]  word_cnt;
    logic [IDX_W-1:0]  flush_cnt;
    logic [WAY_W-1:0]  victim, victim_q;
    logic [31:0]       hold_q;

    logic [TAG_W-1:0]  tag_q  [WAYS];
    logic [31:0]       data_q [WAYS];
    logic [WAYS-1:0]   valid_vec, hit_vec;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic              take;
    cache_state_e      cap_state;

    assign r_tag  = r_addr[TAG_LSB +: TAG_W];
    assign r_idx  = r_addr[IDX_LSB +: IDX_W];
    assign r_word = r_addr[2 +: OFS_W];

    logic             fill_ack, fill_last;
    logic [IDX_W-1:0] inval_idx;
    logic [$clog2(DEPTH)-1:0] dw_addr, dr_addr;
    logic [31:0]      dw_data;

    assign fill_ack  = (state_q == ST_FILL) && mem_ack;
    assign fill_last = fill_ack && (word_cnt == LAST_WORD);
    assign inval_idx = (state_q == ST_FLUSH) ? flush_cnt : r_idx;
    assign dr_addr   = {req_addr[IDX_LSB +: IDX_W], req_addr[2 +: OFS_W]};
    assign dw_addr   = (state_q == ST_FILL) ? {r_idx, word_cnt} : {r_idx, r_word};
    assign dw_data   = (state_q == ST_FILL) ? mem_rdata : r_wdata;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic lookup_store, lookup_swap;
        assign lookup_store = (state_q == ST_LOOKUP) && r_write && !r_swap && hit_vec[w];
        assign lookup_swap  = (state_q == ST_LOOKUP) && r_swap && hit_vec[w];

        ucache_tag_way #(.SETS(SETS), .TAG_W(TAG_W)) u_tag (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (req_addr[IDX_LSB +: IDX_W]),
            .fill_en  (fill_last && (victim_q == WAY_W'(w))),
            .fill_idx (r_idx),
            .fill_tag (r_tag),
            .inval_en (lookup_swap || (state_q == ST_FLUSH)),
            .inval_idx(inval_idx),
            .tag_q    (tag_q[w]),
            .valid_q  (valid_vec[w])
        );

        ucache_data_way #(.DEPTH(DEPTH), .DATA_W(32)) u_data (
            .clk    (clk),
            .rd_addr(dr_addr),
            .wr_en  ((fill_ack && (victim_q == WAY_W'(w))) || lookup_store),
            .wr_addr(dw_addr),
            .wr_data(dw_data),
            .rd_q   (data_q[w])
        );

        assign hit_vec[w] = valid_vec[w] && (tag_q[w] == r_tag);
    end

    ucache_victim #(.WAYS(WAYS)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_vec(valid_vec),
        .victim   (victim)
    );

    assign hit = |hit_vec;
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign take      = !stall;
    assign cap_state = flush ? ST_FLUSH : (req_valid ? ST_LOOKUP : ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: state_d = cap_state;
            ST_LOOKUP: begin
                if (r_swap)       state_d = ST_SWAP_RD;
                else if (r_write) state_d = ST_STORE;
                else if (hit)     state_d = cap_state;
                else              state_d = ST_FILL;
            end
            ST_FILL:    if (fill_last) state_d = ST_DONE;
            ST_STORE:   if (mem_ack)   state_d = ST_DONE;
            ST_SWAP_RD: if (mem_ack)   state_d = ST_SWAP_WR;
            ST_SWAP_WR: if (mem_ack)   state_d = ST_DONE;
            ST_FLUSH:   if (flush_cnt == LAST_SET) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr    <= '0;
            r_wdata   <= '0;
            r_write   <= 1'b0;
            r_swap    <= 1'b0;
            word_cnt  <= '0;
            flush_cnt <= '0;
            victim_q  <= '0;
            hold_q    <= '0;
        end else begin
            if (take) begin
                r_addr  <= req_addr;
                r_wdata <= req_wdata;
                r_write <= req_write;
                r_swap  <= req_swap;
            end
            if (state_q == ST_LOOKUP) victim_q <= victim;
            word_cnt  <= (state_q == ST_FILL) ? (fill_ack ? word_cnt + 1'b1 : word_cnt) : '0;
            flush_cnt <= (state_q == ST_FLUSH) ? flush_cnt + 1'b1 : '0;
            if ((fill_ack && word_cnt == r_word) || (state_q == ST_SWAP_RD && mem_ack))
                hold_q <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        stall     = 1'b1;
        rd_valid  = 1'b0;
        rd_data   = hold_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_lock  = 1'b0;
        mem_addr  = r_addr;
        mem_wdata = r_wdata;
        unique case (state_q)
            ST_IDLE: stall = 1'b0;
            ST_LOOKUP: begin
                if (hit && !r_write && !r_swap) begin
                    stall    = 1'b0;
                    rd_valid = 1'b1;
                    rd_data  = data_q[hit_way];
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {r_tag, r_idx, word_cnt, 2'b00};
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_SWAP_RD: begin
                mem_req  = 1'b1;
                mem_lock = 1'b1;
            end
            ST_SWAP_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_lock = 1'b1;
            end
            ST_DONE: begin
                stall    = 1'b0;
                rd_valid = !r_write || r_swap;
            end
            ST_FLUSH: stall = 1'b1;
            default:  stall = 1'b1;
        endcase
    end

    // R10
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> $onehot0(hit_vec));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ack && !fill_last) |=>
        (state_q == ST_FILL && mem_addr[2 +: OFS_W] == ($past(mem_addr[2 +: OFS_W]) + OFS_W'(1))));

    // R7
    swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_lock && !mem_we && mem_ack) |=>
        (mem_req && mem_we && mem_lock && mem_addr == $past(mem_addr)));

    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && hit && !r_write && !r_swap) |-> (!mem_req && !stall));

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> (!mem_req && !rd_valid));
endmodule

// File: tb/tb_ucache_top.sv
module tb_ucache_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_swap = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        stall, rd_valid, mem_req, mem_we, mem_lock;
    logic [31:0] rd_data, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    ucache_top dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_swap(req_swap), .req_wdata(req_wdata),
        .stall(stall), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [31:0] pattern(int i);
        return (i * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    logic [31:0] mem_arr [16384];
    logic [31:0] ref_arr [16384];
    int rd_cnt = 0, wr_cnt = 0, lock_rd = 0, lock_wr = 0;
    logic [31:0] rd_log [$];

    initial begin
        for (int i = 0; i < 16384; i++) begin
            mem_arr[i] = pattern(i);
            ref_arr[i] = pattern(i);
        end
    end

    // Memory responder: acknowledge one cycle after a request is seen
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem_arr[mem_addr[15:2]] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                if (mem_lock) lock_wr <= lock_wr + 1;
            end else begin
                mem_rdata <= mem_arr[mem_addr[15:2]];
                rd_cnt <= rd_cnt + 1;
                rd_log.push_back(mem_addr);
                if (mem_lock) lock_rd <= lock_rd + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct { logic [31:0] data; string rq; } exp_t;
    exp_t exp_q [$];

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.rq, rd_data, e.data);
            end
        end
    end

    int last_reads, last_writes;
    logic last_hit;

    task automatic access(input logic wr, input logic sw, input logic [31:0] addr,
                          input logic [31:0] wd, input string rq);
        int r0, w0;
        @(negedge clk);
        while (stall) @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_swap = sw; req_wdata = wd;
        if (!wr || sw) exp_q.push_back('{ref_arr[addr[15:2]], rq});
        if (wr || sw) ref_arr[addr[15:2]] = wd;
        r0 = rd_cnt; w0 = wr_cnt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_swap = 1'b0;
        last_hit = rd_valid && !stall;
        while (stall) @(negedge clk);
        @(negedge clk);
        last_reads  = rd_cnt - r0;
        last_writes = wr_cnt - w0;
    endtask

    task automatic finish_run;
        if (exp_q.size() != 0) check("R2 pending reads", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int fcount;
        int misses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stall", stall, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 mem_req", mem_req, 0);

        // R1 / R3 first read misses and fills whole line in order
        rd_log.delete();
        access(0, 0, 32'h0000_0104, 0, "R3 miss data");
        check("R1 first read misses", last_hit, 0);
        check("R3 four reads", last_reads, 4);
        for (int i = 0; i < 4; i++)
            check("R3 fill order", (rd_log.size() > i) ? rd_log[i] : 32'hx, 32'h100 + 4 * i);

        // R2 / R4 other word of the line hits
        access(0, 0, 32'h0000_0108, 0, "R4 hit data");
        check("R4 same line hit", last_hit, 1);
        check("R2 hit no memory reads", last_reads, 0);
        access(0, 0, 32'h0000_010C, 0, "R2 hit data");
        check("R2 hit no stall", last_hit, 1);

        // R5 store hit: write through and update cache
        access(1, 0, 32'h0000_0104, 32'hDEAD_BEEF, "R5");
        check("R5 one memory write", last_writes, 1);
        check("R5 store no read", last_reads, 0);
        access(0, 0, 32'h0000_0104, 0, "R5 updated word");
        check("R5 read after store hits", last_hit, 1);

        // R6 store miss does not allocate
        access(1, 0, 32'h0000_0208, 32'h1234_5678, "R6");
        check("R6 one memory write", last_writes, 1);
        access(0, 0, 32'h0000_0208, 0, "R6 read data");
        check("R6 read after store miss misses", last_reads, 4);

        // R7 swap on cached line
        access(0, 0, 32'h0000_0100, 0, "R7 warm");
        check("R7 warm hit", last_hit, 1);
        access(0, 1, 32'h0000_0100, 32'hCAFE_0001, "R7 swap returns old word");
        check("R7 locked read", lock_rd, 1);
        check("R7 locked write", lock_wr, 1);
        check("R7 one read", last_reads, 1);
        access(0, 0, 32'h0000_0100, 0, "R7 read after swap");
        check("R7 line evicted", last_reads, 4);

        // R8 four tags in one set stay resident
        for (int t = 1; t <= 4; t++) access(0, 0, (t << 12) | 32'h300, 0, "R8 fill data");
        for (int t = 1; t <= 4; t++) begin
            access(0, 0, (t << 12) | 32'h304, 0, "R8 resident data");
            check("R8 resident hit", last_hit, 1);
        end
        access(0, 0, 32'h5300, 0, "R8 fifth tag");
        check("R8 fifth tag misses", last_reads, 4);

        // R9 flush
        @(negedge clk);
        while (stall) @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        fcount = 0;
        while (stall && fcount < 1000) begin
            fcount++;
            @(negedge clk);
        end
        check("R9 flush stall cycles", fcount, 256);
        misses = 0;
        access(0, 0, 32'h0000_0108, 0, "R9 data after flush");
        if (last_reads == 4) misses++;
        access(0, 0, 32'h0000_5304, 0, "R9 data after flush");
        if (last_reads == 4) misses++;
        check("R9 lines invalid after flush", misses, 2);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule